// File: doc/BRIEF.md
# Subranging Flash Code Encoder

This block turns the raw comparator decisions of a two-step (subranging) flash converter into a 10-bit output code. A small estimator of six comparators gives a rough position of the input. From it the block derives a window select that tells the analog side which stretch of the upper ladder the sixteen shared comparators must watch. The window is wider than the estimator region on both sides, so the upper six bits come out right even when the estimator is wrong by up to one sixteenth of full scale.

A conversion takes two strobes. On the coarse strobe the block counts the first-flash decisions, adds them to the window base and registers six upper bits. It also drives those bits out, so the analog side knows which tap to subtract from the input. On the fine strobe the same sixteen comparators, now looking at the residue across the lower ladder, give four lower bits. The full code is registered only at that point, together with a one-cycle valid pulse.

Top module: `subrange_encoder`

## Requirements
- R1: After a synchronous reset, code_out, msb_code, code_vld and pending are all zero.
- R2: win_sel equals the number of ones in est_therm (0 to 6). It is combinational, so it follows est_therm within the same cycle. A value k selects the upper-ladder window whose base is 8·k in units of 1/64 of full scale and which spans 16 such units.
- R3: On a clock edge with coarse_stb high, msb_code becomes min(8·win_sel + ones(cmp_bank), 63) from the next cycle on.
- R4: When the estimator decisions are off from the true input by at most 64 codes (1/16 of full scale) and the comparator banks follow the ideal ladder, code_out equals the true input code.
- R5: Comparator banks are encoded by counting ones, not by locating a transition. A first-flash pattern of 16'h00F7 with win_sel 0 gives msb_code 7, and an estimator pattern of 6'b010111 gives win_sel 4.
- R6: The upper-bit sum saturates at 63. win_sel 6 with all sixteen first-flash decisions high gives msb_code 63, not a wrapped value.
- R7: On a clock edge with fine_stb high while pending is high, code_out becomes {msb_code, lower bits} and code_vld is high for exactly the next cycle. code_out[9:4] holds the upper bits and code_out[3:0] the lower bits.
- R8: The lower bits are min(ones(cmp_bank), 15). All sixteen residue decisions high give 15.
- R9: fine_stb while pending is low is ignored: code_out keeps its value and code_vld stays low.
- R10: code_out changes only with a code_vld pulse. A coarse strobe leaves it unchanged.
- R11: pending rises on the cycle after coarse_stb and stays high until the fine strobe has been taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| est_therm | input | 6 | Estimator comparator decisions |
| win_sel | output | 3 | Window select for the upper-ladder multiplexer (combinational) |
| coarse_stb | input | 1 | Phase 1: capture the first-flash decisions |
| fine_stb | input | 1 | Phase 2: capture the residue decisions and latch the code |
| cmp_bank | input | 16 | Shared 16-comparator decisions (first flash or residue) |
| msb_code | output | 6 | Registered upper six bits, used to select the residue tap |
| pending | output | 1 | Phase 1 taken, waiting for phase 2 |
| code_out | output | 10 | Registered full conversion result |
| code_vld | output | 1 | One-cycle pulse when code_out is updated |

## Verification
The hardest case to reach from the ports is error correction: a wrong estimator decision must still give the exact code. This only happens when the estimator and the first flash disagree about the input, and a port-level stimulus would not produce that disagreement on its own. The bench models the ladders itself and feeds the estimator an input shifted by a chosen error, up to ±64 codes, while the shared bank sees the true input through the window that the block selected. This pushes the input to the lower and upper edges of the selected window, and into the end windows where the sum reaches its ceiling.

// File: rtl/subrange_pkg.sv
package subrange_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_FINE = 1'b1
  } sr_phase_e;

  function automatic int sat_upper(input int val, input int lim);
    return (val > lim) ? lim : val;
  endfunction
endpackage

// File: rtl/sr_ones_count.sv
module sr_ones_count #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/sr_window_sel.sv
module sr_window_sel #(
  parameter int EST_N = 6,
  parameter int MSB_W = 6
) (
  input  logic [EST_N-1:0]             est_therm,
  output logic [$clog2(EST_N+1)-1:0]   win_sel,
  output logic [MSB_W-1:0]             win_base
);
  localparam int WSEL_W   = $clog2(EST_N + 1);
  localparam int WIN_STEP = (1 << MSB_W) / (EST_N + 2);

  logic [WSEL_W-1:0] est_cnt;

  sr_ones_count #(.W(EST_N), .CW(WSEL_W)) u_est_cnt (
    .bits  (est_therm),
    .count (est_cnt)
  );

  always_comb begin
    win_sel  = est_cnt;
    win_base = MSB_W'(int'(est_cnt) * WIN_STEP);
  end
endmodule

// File: rtl/sr_msb_merge.sv
module sr_msb_merge #(
  parameter int FINE_N = 16,
  parameter int MSB_W  = 6
) (
  input  logic [MSB_W-1:0]  win_base,
  input  logic [FINE_N-1:0] cmp_bank,
  output logic [MSB_W-1:0]  msb
);
  localparam int CNT_W   = $clog2(FINE_N + 1);
  localparam int SUM_W   = ((MSB_W > CNT_W) ? MSB_W : CNT_W) + 1;
  localparam int MSB_MAX = (1 << MSB_W) - 1;

  logic [CNT_W-1:0] fl_cnt;
  logic [SUM_W-1:0] sum;

  sr_ones_count #(.W(FINE_N), .CW(CNT_W)) u_fl_cnt (
    .bits  (cmp_bank),
    .count (fl_cnt)
  );

  always_comb begin
    sum = SUM_W'(win_base) + SUM_W'(fl_cnt);
    if (sum > SUM_W'(MSB_MAX)) begin
      msb = MSB_W'(MSB_MAX);
    end else begin
      msb = sum[MSB_W-1:0];
    end
  end
endmodule

// File: rtl/sr_lsb_clamp.sv
module sr_lsb_clamp #(
  parameter int FINE_N = 16,
  parameter int LSB_W  = 4
) (
  input  logic [FINE_N-1:0] cmp_bank,
  output logic [LSB_W-1:0]  lsb
);
  localparam int CNT_W   = $clog2(FINE_N + 1);
  localparam int LSB_MAX = (1 << LSB_W) - 1;

  logic [CNT_W-1:0] res_cnt;

  sr_ones_count #(.W(FINE_N), .CW(CNT_W)) u_res_cnt (
    .bits  (cmp_bank),
    .count (res_cnt)
  );

  generate
    if (CNT_W > LSB_W) begin : g_clamp
      always_comb begin
        if (res_cnt > CNT_W'(LSB_MAX)) begin
          lsb = LSB_W'(LSB_MAX);
        end else begin
          lsb = res_cnt[LSB_W-1:0];
        end
      end
    end else begin : g_widen
      always_comb lsb = LSB_W'(res_cnt);
    end
  endgenerate
endmodule

// File: rtl/subrange_encoder.sv
module subrange_encoder #(
  parameter int EST_N  = 6,
  parameter int FINE_N = 16,
  parameter int MSB_W  = 6,
  parameter int LSB_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [EST_N-1:0]            est_therm,
  output logic [$clog2(EST_N+1)-1:0]  win_sel,
  input  logic                        coarse_stb,
  input  logic                        fine_stb,
  input  logic [FINE_N-1:0]           cmp_bank,
  output logic [MSB_W-1:0]            msb_code,
  output logic                        pending,
  output logic [MSB_W+LSB_W-1:0]      code_out,
  output logic                        code_vld
);
  import subrange_pkg::*;

  localparam int RES_W = MSB_W + LSB_W;

  logic [MSB_W-1:0] win_base;
  logic [MSB_W-1:0] msb_w;
  logic [LSB_W-1:0] lsb_w;
  logic [MSB_W-1:0] msb_q;
  sr_phase_e        phase_q;
  logic             take_fine;

  sr_window_sel #(.EST_N(EST_N), .MSB_W(MSB_W)) u_win (
    .est_therm (est_therm),
    .win_sel   (win_sel),
    .win_base  (win_base)
  );

  sr_msb_merge #(.FINE_N(FINE_N), .MSB_W(MSB_W)) u_msb (
    .win_base (win_base),
    .cmp_bank (cmp_bank),
    .msb      (msb_w)
  );

  sr_lsb_clamp #(.FINE_N(FINE_N), .LSB_W(LSB_W)) u_lsb (
    .cmp_bank (cmp_bank),
    .lsb      (lsb_w)
  );

  assign take_fine = fine_stb && (phase_q == PH_FINE);

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_q    <= '0;
      phase_q  <= PH_IDLE;
      code_out <= '0;
      code_vld <= 1'b0;
    end else begin
      code_vld <= 1'b0;
      if (take_fine) begin
        code_out <= RES_W'({msb_q, lsb_w});
        code_vld <= 1'b1;
      end
      if (coarse_stb) begin
        msb_q   <= msb_w;
        phase_q <= PH_FINE;
      end else if (take_fine) begin
        phase_q <= PH_IDLE;
      end
    end
  end

  assign msb_code = msb_q;
  assign pending  = (phase_q == PH_FINE);
endmodule

// File: rtl/subrange_encoder_chk.sv
module subrange_encoder_chk #(
  parameter int EST_N  = 6,
  parameter int FINE_N = 16,
  parameter int MSB_W  = 6,
  parameter int LSB_W  = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [EST_N-1:0]            est_therm,
  input logic [$clog2(EST_N+1)-1:0]  win_sel,
  input logic                        coarse_stb,
  input logic                        fine_stb,
  input logic [FINE_N-1:0]           cmp_bank,
  input logic [MSB_W-1:0]            msb_code,
  input logic                        pending,
  input logic [MSB_W+LSB_W-1:0]      code_out,
  input logic                        code_vld
);
  localparam int RES_W    = MSB_W + LSB_W;
  localparam int WIN_STEP = (1 << MSB_W) / (EST_N + 2);

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(win_sel) <= EST_N); // R2

  AST_MSB_FLOOR: assert property (@(posedge clk) disable iff (rst)
    coarse_stb |=> (int'(msb_code) >= int'($past(win_sel)) * WIN_STEP)); // R3

  AST_MSB_CEIL: assert property (@(posedge clk) disable iff (rst)
    coarse_stb |=> (int'(msb_code) <= int'($past(win_sel)) * WIN_STEP + FINE_N)); // R3

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    coarse_stb |=> pending); // R11

  AST_FINE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (fine_stb && !pending) |=> (!code_vld && $stable(code_out))); // R9

  AST_VLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> ($past(fine_stb) && $past(pending))); // R7

  AST_CODE_MSB: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> (code_out[RES_W-1:LSB_W] == $past(msb_code))); // R7

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !code_vld |-> $stable(code_out)); // R10
endmodule

bind subrange_encoder subrange_encoder_chk #(
  .EST_N (EST_N),
  .FINE_N(FINE_N),
  .MSB_W (MSB_W),
  .LSB_W (LSB_W)
) u_chk (.*);

// File: tb/subrange_encoder_tb.sv
module subrange_encoder_tb;
  localparam int NV = 10;
  localparam int VEC_V[NV] = '{0, 1023, 512, 300, 300, 767, 768, 100, 1000, 191};
  localparam int VEC_E[NV] = '{0, 0, 0, 64, -64, 40, -64, -64, 64, 1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  est_therm = '0;
  logic [2:0]  win_sel;
  logic        coarse_stb = 1'b0;
  logic        fine_stb = 1'b0;
  logic [15:0] cmp_bank = '0;
  logic [5:0]  msb_code;
  logic        pending;
  logic [9:0]  code_out;
  logic        code_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  subrange_encoder u_dut (
    .clk        (clk),
    .rst        (rst),
    .est_therm  (est_therm),
    .win_sel    (win_sel),
    .coarse_stb (coarse_stb),
    .fine_stb   (fine_stb),
    .cmp_bank   (cmp_bank),
    .msb_code   (msb_code),
    .pending    (pending),
    .code_out   (code_out),
    .code_vld   (code_vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] est_model(input int a);
    logic [5:0] b;
    for (int j = 0; j < 6; j++) b[j] = (a >= (2 * j + 3) * 64);
    return b;
  endfunction

  task automatic conv(input int v, input int e);
    int k;
    int m;
    @(negedge clk);
    est_therm = est_model(v + e);
    k = 0;
    for (int j = 0; j < 6; j++) if (est_therm[j]) k++;
    #1;
    chk("R2 window select", int'(win_sel), k);
    for (int i = 0; i < 16; i++) cmp_bank[i] = (v >= (8 * k + i + 1) * 16);
    coarse_stb = 1'b1;
    @(negedge clk);
    coarse_stb = 1'b0;
    m = v >> 4;
    chk("R3 upper bits", int'(msb_code), m);
    chk("R11 pending set", int'(pending), 1);
    for (int j = 0; j < 16; j++) cmp_bank[j] = ((v - m * 16) >= j + 1);
    fine_stb = 1'b1;
    @(negedge clk);
    fine_stb = 1'b0;
    chk("R4 corrected code", int'(code_out), v);
    chk("R7 valid pulse", int'(code_vld), 1);
    chk("R11 pending cleared", int'(pending), 0);
    @(negedge clk);
    chk("R7 valid one cycle", int'(code_vld), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 code_out", int'(code_out), 0);
    chk("R1 msb_code", int'(msb_code), 0);
    chk("R1 code_vld", int'(code_vld), 0);
    chk("R1 pending", int'(pending), 0);

    for (int n = 0; n < NV; n++) conv(VEC_V[n], VEC_E[n]);

    // R5 bubbles in both banks
    @(negedge clk);
    est_therm = 6'b010111;
    #1;
    chk("R5 estimator bubble", int'(win_sel), 4);
    est_therm = 6'b000000;
    cmp_bank = 16'h00F7;
    coarse_stb = 1'b1;
    @(negedge clk);
    coarse_stb = 1'b0;
    chk("R5 first-flash bubble", int'(msb_code), 7);

    // R6 saturation at the top window
    est_therm = 6'h3F;
    cmp_bank = 16'hFFFF;
    coarse_stb = 1'b1;
    @(negedge clk);
    coarse_stb = 1'b0;
    chk("R6 upper saturation", int'(msb_code), 63);

    // R8 lower clamp
    fine_stb = 1'b1;
    @(negedge clk);
    fine_stb = 1'b0;
    chk("R8 lower clamp", int'(code_out), 1023);

    // R9 fine strobe without pending
    @(negedge clk);
    cmp_bank = 16'h0000;
    fine_stb = 1'b1;
    @(negedge clk);
    fine_stb = 1'b0;
    chk("R9 ignored vld", int'(code_vld), 0);
    chk("R9 ignored code", int'(code_out), 1023);
    chk("R9 pending stays low", int'(pending), 0);

    // R10 coarse strobe leaves result alone
    est_therm = 6'h00;
    cmp_bank = 16'h0003;
    coarse_stb = 1'b1;
    @(negedge clk);
    coarse_stb = 1'b0;
    chk("R10 code held", int'(code_out), 1023);
    chk("R3 new upper bits", int'(msb_code), 2);
    @(negedge clk);
    chk("R11 pending held", int'(pending), 1);
    cmp_bank = 16'h001F;
    fine_stb = 1'b1;
    @(negedge clk);
    fine_stb = 1'b0;
    chk("R7 latched code", int'(code_out), 2 * 16 + 5);
    chk("R11 pending after fine", int'(pending), 0);

    // R1 reset mid-conversion
    cmp_bank = 16'hFFFF;
    coarse_stb = 1'b1;
    @(negedge clk);
    coarse_stb = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset code", int'(code_out), 0);
    chk("R1 reset pending", int'(pending), 0);
    chk("R1 reset msb", int'(msb_code), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule